// File: doc/BRIEF.md
# Masked Polarity-Configurable Interrupt Controller

This block sits between a set of peripheral interrupt lines and a downstream interrupt distributor. Every line passes through a per-line polarity inversion, a per-line status stage and a per-line mask. The block then presents one qualified request per line and a single combined request that is the OR of all of them. Software reaches the mask, polarity and status words over a simple register bus. Each word carries 16 lines in its low half, and the words are aligned to 32 bits.

A build parameter selects one of two variants. The level variant serves 64 lines. Its status follows the polarity-corrected input and needs no clearing. The latched variant serves 32 lines. It captures each rising edge of the polarity-corrected input into a sticky status bit, which software acknowledges by writing ones. Mask, polarity and status words sit in three banks, each 16 bytes apart, and consecutive words within a bank are 4 bytes apart.

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset every mask bit is 1, every polarity bit is 0 and every status bit is 0, and `irq_lines` and `irq_any` are low.
- R2: A line's qualified output `irq_lines[i]` is high only when its status bit is 1 and its mask bit is 0. A mask bit of 1 blocks the line, but a masked latched event is still held in status.
- R3: A polarity bit of 1 inverts the raw input before the status stage, so an active-low source counts as asserted while low.
- R4: Word g of the mask bank is at byte offset 0x00+4g, of the polarity bank at 0x10+4g and of the status bank at 0x20+4g. Line 16g+b maps to bit b of word g.
- R5: `bus_rdata` is registered. It shows the word addressed in the previous cycle, its bits 31:16 are always zero, and only `bus_wdata[15:0]` is stored.
- R6: An offset outside the implemented words reads zero and ignores writes. This covers words past the line count, offsets 0x30 and above, and addresses whose low two bits are not zero.
- R7: In the level variant, a status word reads the polarity-corrected input as sampled in the previous cycle, and writes to status words have no effect.
- R8: In the level variant, `irq_lines` follows the polarity-corrected, masked input with one cycle of latency.
- R9: In the latched variant, a rising edge of the polarity-corrected input sets that line's status bit, and the bit stays set after the input falls.
- R10: In the latched variant, writing 1 to a status bit clears it and writing 0 leaves it unchanged.
- R11: In the latched variant, a rising edge in the same cycle as a clear of that bit leaves the bit set.
- R12: `irq_any` is the registered OR of all qualified lines, and it rises one cycle after the input event that qualifies a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | NLINES | Raw peripheral interrupt lines (64 level, 32 latched) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data; low 16 bits used |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | output | NLINES | Per-line qualified interrupt requests |
| irq_any | output | 1 | Combined registered request |

## Verification
The bench builds the block twice, once with `LATCHED=0` for 64 lines and once with `LATCHED=1` for 32 lines, and drives both over the same address and data wires.

The level build gives access to all four words of each bank. A vector table there combines polarity and mask patterns in every group, and the bench checks the status read-back against each pattern.

The latched build gives access to the sticky status path. That covers an edge captured while its line is masked, a clear written with 0 and with 1, and an edge that lands in the same cycle as its clear. It also covers the word offsets that become unmapped once only two groups exist.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    K_MASK = 2'd0,
    K_POL  = 2'd1,
    K_STAT = 2'd2,
    K_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int GROUPS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_kind_e         kind,
  output logic [1:0]        grp,
  output logic              hit,
  output logic [GROUPS-1:0] we_mask,
  output logic [GROUPS-1:0] we_pol,
  output logic [GROUPS-1:0] we_stat
);
  // Byte address layout: [5:4] bank, [3:2] word in bank, [1:0] must be zero.
  always_comb begin
    kind = reg_kind_e'(addr[5:4]);
    grp  = addr[3:2];
    hit  = (addr[ADDR_W-1:6] == '0) && (addr[1:0] == 2'b00) &&
           (kind != K_NONE) && (int'(grp) < GROUPS);
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_we
    always_comb begin
      we_mask[g] = we && hit && (grp == 2'(g)) && (kind == K_MASK);
      we_pol[g]  = we && hit && (grp == 2'(g)) && (kind == K_POL);
      we_stat[g] = we && hit && (grp == 2'(g)) && (kind == K_STAT);
    end
  end
endmodule

// File: rtl/irqc_lane.sv
module irqc_lane #(
  parameter int W       = 16,
  parameter bit LATCHED = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic         we_mask,
  input  logic         we_pol,
  input  logic         we_stat,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] qual_d
);
  logic [W-1:0] mask_d, pol_d, stat_d, eff;

  always_comb begin
    mask_d = we_mask ? wdata : mask_q;
    pol_d  = we_pol  ? wdata : pol_q;
    eff    = raw ^ pol_q;
  end

  if (LATCHED) begin : g_latch
    logic [W-1:0] eff_q, rise, clr;

    always_comb begin
      rise   = eff & ~eff_q;
      clr    = we_stat ? wdata : '0;
      stat_d = (stat_q & ~clr) | rise;   // a new edge beats a clear
    end

    always_ff @(posedge clk) begin
      if (rst) eff_q <= '0;
      else     eff_q <= eff;
    end

    // A status bit only falls when a 1 was written to it.
    p_clear_only_by_one_r10: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((($past(stat_q) & ~stat_q) & ~$past(clr)) == '0));
    // A captured edge is visible in status the next cycle, clear or not.
    p_edge_wins_r11: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (($past(rise) & ~stat_q) == '0));
  end else begin : g_level
    logic stat_we_unused;
    assign stat_we_unused = we_stat;
    always_comb stat_d = eff;

    p_status_follows_r7: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (stat_q == $past(raw ^ pol_q)));
  end

  always_comb qual_d = stat_d & ~mask_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      pol_q  <= '0;
      stat_q <= '0;
    end else begin
      mask_q <= mask_d;
      pol_q  <= pol_d;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter bit LATCHED = 1'b0,
  parameter int ADDR_W  = 8,
  localparam int NLINES = LATCHED ? 32 : 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_raw,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NLINES-1:0] irq_lines,
  output logic              irq_any
);
  localparam int GROUPS = NLINES / REG_W;

  reg_kind_e         kind;
  logic [1:0]        grp;
  logic              hit;
  logic [GROUPS-1:0] we_mask, we_pol, we_stat;
  logic [REG_W-1:0]  mask_w [GROUPS];
  logic [REG_W-1:0]  pol_w  [GROUPS];
  logic [REG_W-1:0]  stat_w [GROUPS];
  logic [NLINES-1:0] qual_all, mask_all;
  logic [REG_W-1:0]  rd_sel;
  logic [15:0]       wdata_hi_unused;

  assign wdata_hi_unused = bus_wdata[31:16];

  irqc_decode #(.ADDR_W(ADDR_W), .GROUPS(GROUPS)) u_dec (
    .addr(bus_addr), .we(bus_we), .kind(kind), .grp(grp), .hit(hit),
    .we_mask(we_mask), .we_pol(we_pol), .we_stat(we_stat)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    irqc_lane #(.W(REG_W), .LATCHED(LATCHED)) u_lane (
      .clk(clk), .rst(rst),
      .raw(irq_raw[g*REG_W +: REG_W]),
      .we_mask(we_mask[g]), .we_pol(we_pol[g]), .we_stat(we_stat[g]),
      .wdata(bus_wdata[REG_W-1:0]),
      .mask_q(mask_w[g]), .pol_q(pol_w[g]), .stat_q(stat_w[g]),
      .qual_d(qual_all[g*REG_W +: REG_W])
    );
    assign mask_all[g*REG_W +: REG_W] = mask_w[g];
  end

  always_comb begin
    rd_sel = '0;
    if (hit) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (grp == 2'(g)) begin
          case (kind)
            K_MASK:  rd_sel = mask_w[g];
            K_POL:   rd_sel = pol_w[g];
            K_STAT:  rd_sel = stat_w[g];
            default: rd_sel = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lines <= '0;
      irq_any   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq_lines <= qual_all;
      irq_any   <= |qual_all;
      bus_rdata <= {16'h0000, rd_sel};
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (mask_all == '1 && irq_lines == '0 && !irq_any));
  p_mask_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_lines & mask_all) == '0);
  p_rdata_upper_r5: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[31:16] == 16'h0000);
  p_any_is_or_r12: assert property (@(posedge clk) disable iff (rst)
    irq_any == (|irq_lines));
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] raw_l = '0;
  logic [31:0] raw_t = '0;
  logic        we_l = 1'b0, we_t = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_l, rdata_t;
  logic [63:0] irq_l;
  logic [31:0] irq_t;
  logic        any_l, any_t;
  int          total = 0, fails = 0;

  always #5 clk = ~clk;

  irqc_top #(.LATCHED(1'b0)) u_dut (
    .clk(clk), .rst(rst), .irq_raw(raw_l), .bus_we(we_l), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_l), .irq_lines(irq_l), .irq_any(any_l)
  );

  irqc_top #(.LATCHED(1'b1)) u_dut_latched (
    .clk(clk), .rst(rst), .irq_raw(raw_t), .bus_we(we_t), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_t), .irq_lines(irq_t), .irq_any(any_t)
  );

  // {group[1:0], polarity, mask, raw, expected qualified}
  localparam logic [65:0] VEC [8] = '{
    {2'd0, 16'h0000, 16'h0000, 16'h00F0, 16'h00F0},
    {2'd0, 16'h0000, 16'h00F0, 16'h00FF, 16'h000F},
    {2'd1, 16'hFFFF, 16'h0000, 16'hFF00, 16'h00FF},
    {2'd2, 16'h0F0F, 16'hFF00, 16'h0000, 16'h000F},
    {2'd3, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000},
    {2'd3, 16'h8000, 16'h0000, 16'h0001, 16'h8001},
    {2'd1, 16'h0000, 16'h7FFE, 16'hFFFF, 16'h8001},
    {2'd0, 16'hAAAA, 16'h0000, 16'hAAAA, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit lt, input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d;
    if (lt) we_t = 1'b1; else we_l = 1'b1;
    @(negedge clk);
    we_t = 1'b0; we_l = 1'b0;
  endtask

  task automatic rd(input bit lt, input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = lt ? rdata_t : rdata_l;
  endtask

  task automatic restore_level();
    for (int g = 0; g < 4; g++) begin
      wr(1'b0, 8'(4*g), 32'h0000_FFFF);
      wr(1'b0, 8'(16 + 4*g), 32'h0);
    end
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq level", {31'b0, any_l} | irq_l[31:0] | irq_l[63:32], 32'h0);
    chk("R1 irq latched", irq_t | {31'b0, any_t}, 32'h0);
    rd(1'b0, 8'h00, d); chk("R1 mask g0", d, 32'h0000_FFFF);
    rd(1'b0, 8'h0C, d); chk("R1 mask g3", d, 32'h0000_FFFF);
    rd(1'b0, 8'h1C, d); chk("R1 pol g3", d, 32'h0);
    rd(1'b1, 8'h24, d); chk("R1 status latched g1", d, 32'h0);

    // R2 R3 R4 R7 R8 R12: vector table on the level build
    for (int i = 0; i < 8; i++) begin
      int g;
      g = int'(VEC[i][65:64]);
      raw_l = '0;
      restore_level();
      wr(1'b0, 8'(16 + 4*g), {16'h0, VEC[i][63:48]});
      wr(1'b0, 8'(4*g),      {16'h0, VEC[i][47:32]});
      raw_l[g*16 +: 16] = VEC[i][31:16];
      @(negedge clk);
      chk($sformatf("R2 R3 R8 vec%0d lines", i), {16'h0, irq_l[g*16 +: 16]}, {16'h0, VEC[i][15:0]});
      chk($sformatf("R12 vec%0d any", i), {31'b0, any_l}, {31'b0, VEC[i][15:0] != 16'h0});
      rd(1'b0, 8'(32 + 4*g), d);
      chk($sformatf("R4 R7 vec%0d status", i), d, {16'h0, VEC[i][31:16] ^ VEC[i][63:48]});
    end
    raw_l = '0;
    restore_level();

    // R7 status write ignored in level build
    wr(1'b0, 8'h20, 32'h0000_FFFF);
    rd(1'b0, 8'h20, d); chk("R7 status write ignored", d, 32'h0);
    // R5 upper data bits dropped, reads zero-extended
    wr(1'b0, 8'h10, 32'hABCD_1234);
    rd(1'b0, 8'h10, d); chk("R5 upper bits", d, 32'h0000_1234);
    rd(1'b0, 8'h14, d); chk("R4 neighbour untouched", d, 32'h0);
    wr(1'b0, 8'h10, 32'h0);
    // R6 unmapped offsets on level build
    wr(1'b0, 8'h30, 32'hFFFF);
    rd(1'b0, 8'h30, d); chk("R6 offset 0x30", d, 32'h0);
    wr(1'b0, 8'h01, 32'h0000);
    rd(1'b0, 8'h00, d); chk("R6 unaligned write ignored", d, 32'h0000_FFFF);

    // R9 R12 latched capture
    wr(1'b1, 8'h00, 32'h0000_FFF7);
    chk("R12 any idle", {31'b0, any_t}, 32'h0);
    raw_t[3] = 1'b1;
    @(negedge clk);
    chk("R9 line3 set", {31'b0, irq_t[3]}, 32'h1);
    chk("R12 any one cycle", {31'b0, any_t}, 32'h1);
    raw_t[3] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 line3 held", {31'b0, irq_t[3]}, 32'h1);
    rd(1'b1, 8'h20, d); chk("R9 status held", d, 32'h0000_0008);

    // R10 write-one-to-clear
    wr(1'b1, 8'h20, 32'h0);
    rd(1'b1, 8'h20, d); chk("R10 zero write no effect", d, 32'h0000_0008);
    wr(1'b1, 8'h20, 32'h0000_0008);
    chk("R10 line cleared", irq_t | {31'b0, any_t}, 32'h0);
    rd(1'b1, 8'h20, d); chk("R10 status cleared", d, 32'h0);

    // R11 edge and clear in the same cycle
    raw_t[3] = 1'b1; @(negedge clk);
    raw_t[3] = 1'b0; @(negedge clk);
    bus_addr = 8'h20; bus_wdata = 32'h0000_0008; we_t = 1'b1; raw_t[3] = 1'b1;
    @(negedge clk);
    we_t = 1'b0;
    chk("R11 edge beats clear", {31'b0, irq_t[3]}, 32'h1);
    rd(1'b1, 8'h20, d); chk("R11 status kept", d, 32'h0000_0008);
    wr(1'b1, 8'h20, 32'h0000_0008);
    rd(1'b1, 8'h20, d); chk("R10 clear while input high", d, 32'h0);

    // R2 masked event held, released by unmask
    raw_t[5] = 1'b1; @(negedge clk);
    raw_t[5] = 1'b0; @(negedge clk);
    chk("R2 masked line low", {31'b0, irq_t[5]}, 32'h0);
    chk("R2 masked any low", {31'b0, any_t}, 32'h0);
    rd(1'b1, 8'h20, d); chk("R2 masked status held", d, 32'h0000_0020);
    wr(1'b1, 8'h00, 32'h0000_FFD7);
    chk("R2 unmask releases", {31'b0, irq_t[5]}, 32'h1);

    // R3 polarity on latched group 1 makes an idle-low input assert
    wr(1'b1, 8'h14, 32'h0000_0001);
    @(negedge clk);
    rd(1'b1, 8'h24, d); chk("R3 inverted capture", d, 32'h0000_0001);

    // R6 offsets past 32 lines on latched build
    wr(1'b1, 8'h28, 32'hFFFF);
    rd(1'b1, 8'h28, d); chk("R6 status g2 absent", d, 32'h0);
    wr(1'b1, 8'h18, 32'hFFFF);
    rd(1'b1, 8'h18, d); chk("R6 pol g2 absent", d, 32'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule